// File: doc/BRIEF.md
# Debug Halt and Resume Controller

This block is the control state machine on the processor side that decides when the core stops for debug and how it restarts. It has three sources of halt requests: an external breakpoint pin, a halt command from the debug port, and an internal hardware breakpoint. Each request is held as pending. The core acts on it only at the one sample point that each instruction offers, or at once when the core sits in STOP mode.

There is a short window just after reset is negated. A breakpoint on the pin during that window stops the core before reset exception processing begins, and that halt is the only time an emulation-mode bit can be set. On a GO command the block picks where execution resumes, from the kind of halt and from whether the PC was written while halted. It then pulses one of three resume-target signals. A 4-bit halt-source field records the cause and follows fixed clear rules.

States:
- `ST_RST_WAIT`: waits 16 cycles after reset is negated.
- `ST_RUN`: normal execution.
- `ST_HALT_RST`: halted from the post-reset window.
- `ST_HALT_RUN`: halted at an instruction sample.
- `ST_HALT_STOP`: halted after a wake from STOP.

Transitions:
- wait to halt-reset: pin asserted inside the window.
- wait to run: end of the wait.
- run to halt-run: request pending at a sample strobe.
- run to halt-stop: request pending while `stop_mode` is high.
- any halt state to run: GO.

Top module: `dbg_halt_ctl`

## Requirements
- R1: While reset is held and just after it, `halted`, `rst_exc_start`, all resume pulses, `emu_mode` and `halt_src` are 0, and `pst` is 0x0.
- R2: With no breakpoint, `rst_exc_start` is high for exactly one cycle. That cycle is the 16th clock after reset negation, when the counter that starts at 0 on negation reads 15. The block then runs.
- R3: If `bkpt_pin` is sampled high on any of the first 8 clock edges after negation, the block enters `ST_HALT_RST` and `halt_src` becomes 4'b1100. A pin pulse on edges 9 to 16 does not halt at once. It stays pending.
- R4: A request from any source is latched as pending. In run it causes a halt only on an edge where `insn_sample` is high, or where `stop_mode` is high.
- R5: `pst` is 0xF whenever `halted` is high, and 0x0 otherwise.
- R6: `emu_set_req` sets `emu_mode` only in `ST_HALT_RST`. At any other time it has no effect. `emu_mode` is cleared only by reset.
- R7: A GO in `ST_HALT_RST` pulses `resume_pc` when `pc_written` is high, and `resume_reset` otherwise. At most one resume pulse is high at a time.
- R8: A GO in `ST_HALT_RUN` or `ST_HALT_STOP` pulses `resume_pc` when `pc_written` is high, and `resume_next` otherwise. Each resume pulse lasts one cycle, in the cycle after the GO edge.
- R9: On entry to a halt from run, `halt_src` becomes {0, one-hot of the highest-priority pending source}. The one-hot bit positions are bit 2 for the pin, bit 1 for the halt command and bit 0 for the hardware breakpoint, and the pin has the highest priority. Bit 3 is set only for a post-reset-window halt.
- R10: An accepted GO clears `halt_src[2:0]` and leaves `halt_src[3]` unchanged.
- R11: With `CLR_ON_READ`=1 (the default), a `csr_rd` pulse clears all of `halt_src`. A halt entry in the same cycle takes precedence.
- R12: A GO while not halted does nothing. Requests that arrive while halted are dropped, and entering a halt clears every pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bkpt_pin | input | 1 | External breakpoint request |
| halt_cmd | input | 1 | Halt command from the debug port |
| hw_bkpt | input | 1 | Internal hardware breakpoint hit |
| insn_sample | input | 1 | Per-instruction sample strobe |
| stop_mode | input | 1 | Core is in STOP mode |
| go_cmd | input | 1 | Debug GO command |
| pc_written | input | 1 | PC was written while halted |
| emu_set_req | input | 1 | Request to set emulation mode |
| csr_rd | input | 1 | One-cycle status register read strobe |
| halted | output | 1 | Core is halted for debug |
| pst | output | 4 | Processor status code |
| rst_exc_start | output | 1 | Start reset exception processing |
| resume_pc | output | 1 | Resume at the written PC |
| resume_reset | output | 1 | Continue reset exception processing |
| resume_next | output | 1 | Resume at the next sequential instruction |
| emu_mode | output | 1 | Emulation mode enabled |
| halt_src | output | 4 | Halt-source field |

## Verification
The post-reset window is swept over every pin arrival cycle from 0 to 15. Early arrivals must halt at once with bit 3 set, and late ones must halt only at the first sample in run and without bit 3. All seven combinations of simultaneous requests are applied at a sample edge, and the result is compared with a priority encoding computed in the bench. Each combination alternates `pc_written`, which separates the PC target from the next-instruction target. A request without a sample strobe, a pin pulse in STOP, requests that arrive while halted, and GO or emulation requests outside their valid states show the difference between deferred, immediate and ignored stimulus.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
    typedef enum logic [2:0] {
        ST_RST_WAIT,
        ST_RUN,
        ST_HALT_RST,
        ST_HALT_RUN,
        ST_HALT_STOP
    } dbg_state_e;

    localparam int          NSRC     = 3;
    localparam int          SRC_HW   = 0;
    localparam int          SRC_CMD  = 1;
    localparam int          SRC_PIN  = 2;
    localparam int          FIELD_W  = 4;
    localparam logic [3:0]  PST_HALT = 4'hF;
    localparam logic [3:0]  PST_RUN  = 4'h0;
endpackage

// File: rtl/dbg_rst_window.sv
module dbg_rst_window #(
    parameter int WAIT_CYC = 16,
    parameter int WIN_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic in_win,
    output logic done
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (active && cnt_q != CW'(WAIT_CYC))
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        in_win = active && (cnt_q < CW'(WIN_CYC));
        done   = active && (cnt_q == CW'(WAIT_CYC - 1));
    end
endmodule

// File: rtl/dbg_req_pend.sv
module dbg_req_pend #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic            capture,
    input  logic            clear,
    output logic [NSRC-1:0] top_oh,
    output logic            any
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] pend_d;
    logic [NSRC-1:0] pend_now;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign pend_now[i] = pend_q[i] | (capture & req[i]);
        assign pend_d[i]   = clear ? 1'b0 : pend_now[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= pend_d;
    end

    always_comb begin
        logic seen;
        seen   = 1'b0;
        top_oh = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            top_oh[i] = pend_now[i] & ~seen;
            seen      = seen | pend_now[i];
        end
        any = |pend_now;
    end
endmodule

// File: rtl/dbg_halt_src.sv
module dbg_halt_src #(
    parameter bit CLR_ON_READ = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  logic [3:0] set_val,
    input  logic       go_clr,
    input  logic       rd_clr,
    output logic [3:0] field
);
    logic [3:0] field_q;
    logic [3:0] field_d;
    logic       rd_eff;

    if (CLR_ON_READ) begin : g_rdclr
        assign rd_eff = rd_clr;
    end else begin : g_rdkeep
        assign rd_eff = 1'b0;
    end

    always_comb begin
        field_d = field_q;
        if (go_clr)
            field_d[2:0] = 3'b000;
        if (rd_eff)
            field_d = 4'b0000;
        if (set_en)
            field_d = set_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            field_q <= '0;
        else
            field_q <= field_d;
    end

    assign field = field_q;
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
    import dbg_halt_pkg::*;
#(
    parameter int WAIT_CYC    = 16,
    parameter int WIN_CYC     = 8,
    parameter bit CLR_ON_READ = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bkpt_pin,
    input  logic       halt_cmd,
    input  logic       hw_bkpt,
    input  logic       insn_sample,
    input  logic       stop_mode,
    input  logic       go_cmd,
    input  logic       pc_written,
    input  logic       emu_set_req,
    input  logic       csr_rd,
    output logic       halted,
    output logic [3:0] pst,
    output logic       rst_exc_start,
    output logic       resume_pc,
    output logic       resume_reset,
    output logic       resume_next,
    output logic       emu_mode,
    output logic [3:0] halt_src
);
    dbg_state_e      state_q, state_d;
    logic            in_win, wait_done;
    logic            pend_any;
    logic [NSRC-1:0] pend_oh;
    logic [NSRC-1:0] req_vec;
    logic            capture;
    logic            enter_halt;
    logic [3:0]      src_val;
    logic            go_acc;
    logic            rpc_d, rrst_d, rnext_d;
    logic            rpc_q, rrst_q, rnext_q;
    logic            emu_q;

    assign req_vec[SRC_PIN] = bkpt_pin;
    assign req_vec[SRC_CMD] = halt_cmd;
    assign req_vec[SRC_HW]  = hw_bkpt;
    assign capture = (state_q == ST_RST_WAIT) || (state_q == ST_RUN);

    dbg_rst_window #(.WAIT_CYC(WAIT_CYC), .WIN_CYC(WIN_CYC)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == ST_RST_WAIT),
        .in_win (in_win),
        .done   (wait_done)
    );

    dbg_req_pend #(.NSRC(NSRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_vec),
        .capture (capture),
        .clear   (enter_halt),
        .top_oh  (pend_oh),
        .any     (pend_any)
    );

    dbg_halt_src #(.CLR_ON_READ(CLR_ON_READ)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (enter_halt),
        .set_val (src_val),
        .go_clr  (go_acc),
        .rd_clr  (csr_rd),
        .field   (halt_src)
    );

    // next-state and transition decisions
    always_comb begin
        state_d    = state_q;
        enter_halt = 1'b0;
        src_val    = 4'b0000;
        go_acc     = 1'b0;
        rpc_d      = 1'b0;
        rrst_d     = 1'b0;
        rnext_d    = 1'b0;
        unique case (state_q)
            ST_RST_WAIT: begin
                if (bkpt_pin && in_win) begin
                    state_d    = ST_HALT_RST;
                    enter_halt = 1'b1;
                    src_val    = 4'b1100;
                end else if (wait_done) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (pend_any && (stop_mode || insn_sample)) begin
                    state_d    = stop_mode ? ST_HALT_STOP : ST_HALT_RUN;
                    enter_halt = 1'b1;
                    src_val    = {1'b0, pend_oh};
                end
            end
            ST_HALT_RST: begin
                if (go_cmd) begin
                    state_d = ST_RUN;
                    go_acc  = 1'b1;
                    rpc_d   = pc_written;
                    rrst_d  = !pc_written;
                end
            end
            ST_HALT_RUN, ST_HALT_STOP: begin
                if (go_cmd) begin
                    state_d = ST_RUN;
                    go_acc  = 1'b1;
                    rpc_d   = pc_written;
                    rnext_d = !pc_written;
                end
            end
            default: state_d = ST_RST_WAIT;
        endcase
    end

    // state register and registered pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RST_WAIT;
            rpc_q   <= 1'b0;
            rrst_q  <= 1'b0;
            rnext_q <= 1'b0;
            emu_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rpc_q   <= rpc_d;
            rrst_q  <= rrst_d;
            rnext_q <= rnext_d;
            if (state_q == ST_HALT_RST && emu_set_req)
                emu_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        halted        = (state_q == ST_HALT_RST) || (state_q == ST_HALT_RUN) ||
                        (state_q == ST_HALT_STOP);
        pst           = halted ? PST_HALT : PST_RUN;
        rst_exc_start = (state_q == ST_RST_WAIT) && wait_done && !(bkpt_pin && in_win);
        resume_pc     = rpc_q;
        resume_reset  = rrst_q;
        resume_next   = rnext_q;
        emu_mode      = emu_q;
    end
endmodule

// File: rtl/dbg_halt_ctl_chk.sv
module dbg_halt_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go_cmd,
    input logic       csr_rd,
    input logic       halted,
    input logic [3:0] pst,
    input logic       resume_pc,
    input logic       resume_reset,
    input logic       resume_next,
    input logic       emu_mode,
    input logic [3:0] halt_src
);
    // R5
    pst_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> pst == 4'hF);

    // R5
    pst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |-> pst == 4'h0);

    // R7
    resume_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resume_pc, resume_reset, resume_next}));

    // R12
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && go_cmd) |=> !(resume_pc || resume_reset || resume_next));

    // R10
    go_keep_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && go_cmd && !csr_rd) |=>
            (halt_src[2:0] == 3'b000 && halt_src[3] == $past(halt_src[3])));

    // R6
    emu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(emu_mode) |-> $past(halted));

    // R3
    rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_src[3]) |-> halted);

    // R9
    src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> $onehot0(halt_src[2:0]));
endmodule

bind dbg_halt_ctl dbg_halt_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_cmd       (go_cmd),
    .csr_rd       (csr_rd),
    .halted       (halted),
    .pst          (pst),
    .resume_pc    (resume_pc),
    .resume_reset (resume_reset),
    .resume_next  (resume_next),
    .emu_mode     (emu_mode),
    .halt_src     (halt_src)
);

// File: tb/dbg_halt_ctl_tb.sv
`timescale 1ns/1ps
module dbg_halt_ctl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bkpt_pin = 0, halt_cmd = 0, hw_bkpt = 0, insn_sample = 0, stop_mode = 0;
    logic go_cmd = 0, pc_written = 0, emu_set_req = 0, csr_rd = 0;
    logic halted, rst_exc_start, resume_pc, resume_reset, resume_next, emu_mode;
    logic [3:0] pst, halt_src;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dbg_halt_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bkpt_pin(bkpt_pin), .halt_cmd(halt_cmd),
        .hw_bkpt(hw_bkpt), .insn_sample(insn_sample), .stop_mode(stop_mode),
        .go_cmd(go_cmd), .pc_written(pc_written), .emu_set_req(emu_set_req),
        .csr_rd(csr_rd), .halted(halted), .pst(pst), .rst_exc_start(rst_exc_start),
        .resume_pc(resume_pc), .resume_reset(resume_reset), .resume_next(resume_next),
        .emu_mode(emu_mode), .halt_src(halt_src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic to_run();
        do_reset();
        repeat (16) step();
    endtask

    task automatic go(input logic pcw);
        go_cmd = 1'b1;
        pc_written = pcw;
        step();
        go_cmd = 1'b0;
        pc_written = 1'b0;
    endtask

    initial begin
        // R1 reset state
        @(negedge clk);
        chk("R1 halted", halted, 0);
        chk("R1 pst", pst, 0);
        chk("R1 src", halt_src, 0);
        chk("R1 resume", {resume_pc, resume_reset, resume_next}, 0);
        chk("R1 emu", emu_mode, 0);

        // R2 reset exception start timing
        do_reset();
        chk("R1 after release", {halted, rst_exc_start}, 0);
        repeat (14) step();
        chk("R2 before 16th", rst_exc_start, 0);
        step();
        chk("R2 16th cycle", rst_exc_start, 1);
        step();
        chk("R2 after start", {rst_exc_start, halted}, 0);

        // R3 window sweep over every arrival cycle
        for (int k = 0; k < 16; k++) begin
            do_reset();
            repeat (k) step();
            bkpt_pin = 1'b1;
            step();
            bkpt_pin = 1'b0;
            if (k < 8) begin
                chk("R3 early pin halts", halted, 1);
                chk("R3 early src", halt_src, 4'b1100);
                chk("R5 pst halted", pst, 4'hF);
            end else begin
                chk("R3 late pin no halt", halted, 0);
                repeat (15 - k) step();
                chk("R3 late still running", halted, 0);
                insn_sample = 1'b1;
                step();
                insn_sample = 1'b0;
                chk("R4 late pin halts at sample", halted, 1);
                chk("R9 late src", halt_src, 4'b0100);
            end
            go(1'b0);
        end

        // R6 emu in reset halt, R7 GO targets, R10 keep top, R11 read clear
        for (int p = 0; p < 2; p++) begin
            do_reset();
            bkpt_pin = 1'b1;
            step();
            bkpt_pin = 1'b0;
            emu_set_req = 1'b1;
            step();
            emu_set_req = 1'b0;
            chk("R6 emu set in reset halt", emu_mode, 1);
            go(p[0]);
            chk("R7 resume_pc", resume_pc, p[0]);
            chk("R7 resume_reset", resume_reset, !p[0]);
            chk("R7 resume_next", resume_next, 0);
            chk("R10 top kept", halt_src, 4'b1000);
            step();
            chk("R8 pulse one cycle", {resume_pc, resume_reset}, 0);
            csr_rd = 1'b1;
            step();
            csr_rd = 1'b0;
            chk("R11 read clears", halt_src, 0);
        end

        // R6 emu ignored outside reset halt
        to_run();
        emu_set_req = 1'b1;
        step();
        chk("R6 emu ignored in run", emu_mode, 0);
        halt_cmd = 1'b1;
        insn_sample = 1'b1;
        step();
        halt_cmd = 1'b0;
        insn_sample = 1'b0;
        step();
        emu_set_req = 1'b0;
        chk("R6 emu ignored in run halt", emu_mode, 0);
        go(1'b0);

        // R4 pending without sample
        to_run();
        halt_cmd = 1'b1;
        step();
        halt_cmd = 1'b0;
        repeat (3) step();
        chk("R4 no halt without sample", halted, 0);
        insn_sample = 1'b1;
        step();
        insn_sample = 1'b0;
        chk("R4 halt at sample", halted, 1);
        chk("R9 cmd src", halt_src, 4'b0010);
        // R12 request while halted dropped
        hw_bkpt = 1'b1;
        step();
        hw_bkpt = 1'b0;
        go(1'b0);
        chk("R8 resume_next", resume_next, 1);
        insn_sample = 1'b1;
        step();
        insn_sample = 1'b0;
        chk("R12 pending cleared and drop", halted, 0);

        // R12 GO while running
        go(1'b1);
        chk("R12 go ignored", {resume_pc, resume_reset, resume_next, halted}, 0);

        // R9 priority sweep over all request combinations
        for (int m = 1; m < 8; m++) begin
            logic [3:0] exp_src;
            exp_src = m[2] ? 4'b0100 : (m[1] ? 4'b0010 : 4'b0001);
            bkpt_pin = m[2];
            halt_cmd = m[1];
            hw_bkpt = m[0];
            insn_sample = 1'b1;
            step();
            {bkpt_pin, halt_cmd, hw_bkpt, insn_sample} = 4'b0000;
            chk("R9 halted", halted, 1);
            chk("R9 priority", halt_src, exp_src);
            chk("R5 pst", pst, 4'hF);
            go(m[0]);
            chk("R8 resume_pc", resume_pc, m[0]);
            chk("R8 resume_next", resume_next, !m[0]);
            chk("R10 low cleared", halt_src, 0);
            chk("R5 pst run", pst, 0);
        end

        // R8 wake from STOP
        stop_mode = 1'b1;
        step();
        chk("R8 stop no request", halted, 0);
        bkpt_pin = 1'b1;
        step();
        bkpt_pin = 1'b0;
        stop_mode = 1'b0;
        chk("R8 stop wake halts", halted, 1);
        chk("R9 stop src", halt_src, 4'b0100);
        go(1'b0);
        chk("R8 stop resume next", {resume_pc, resume_reset, resume_next}, 3'b001);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule